// File: doc/BRIEF.md
# Run/Stop Mode Controller with Switch Fault Clear

This block decides the operating mode of a controller from a two-position Run/Stop switch that has already been debounced. It picks between running, stopped with I/O still being scanned, stopped with no I/O scan, and stopped because of a fatal fault. It also drives a two-colour Run indicator and a Fault indicator. Time is measured in millisecond ticks from outside, so every duration is a number of ticks.

Non-fatal conditions never hold the controller back. With switch control enabled, putting the switch in Run starts the controller and leaves the fault record alone. A fatal fault is different. It latches the Stopped/Faulted mode, and the switch alone can clear it. Moving the switch from Stop to Run opens a timed window, and the Run indicator blinks while the window is open. Inside that window the switch must stay in Run for a minimum dwell, then in Stop for a minimum dwell, and then return to Run. When that happens the block raises a one-cycle request to clear the fault tables and enters Run. If the window runs out first, the indicator goes dark and the fault stays.

Top module: `runstop_ctrl`

## Requirements
- R1: During and after reset, with the switch in Stop, the mode is a stopped mode chosen by `stop_io_scan`, the Fault indicator is off and `clr_req` is low.
- R2: With `sw_ctl_en` high and `fatal_flt` low, the mode changes one cycle after the switch level. Run gives mode 0, and Stop gives mode 1 or 2 according to `stop_io_scan`. `clr_req` stays low on these changes.
- R3: With `sw_ctl_en` low, switch movements are ignored and the run/stop mode is held.
- R4: `fatal_flt` high in any non-faulted mode gives mode 3 one cycle later. The Fault indicator is on exactly while the mode is 3. A switch that is already in Run when the fault arrives opens no window.
- R5: In mode 3 with `sw_ctl_en` high, a Stop-to-Run switch transition opens a clear window. While the window is open the green die blinks, starting on and changing state every BLINK_HALF_MS ticks. With `sw_ctl_en` low, no window opens.
- R6: In an open window, a Run dwell of at least MIN_DWELL_MS ticks, then a Stop dwell of at least MIN_DWELL_MS ticks, then a return to Run, raises `clr_req` for exactly one cycle in the cycle that mode 0 appears. The green die is steady on afterwards.
- R7: A Run dwell shorter than MIN_DWELL_MS restarts the sequence at the next Run. A short Stop dwell makes the new Run the first dwell. Neither restart moves the end of the window.
- R8: The window closes WINDOW_MS ticks after it opens. The Run indicator then goes off, the mode stays 3 and `clr_req` stays low. A later Stop-to-Run transition opens a new window.
- R9: The Run indicator shows green only (`run_led_g`=1, `run_led_r`=0) in mode 0. In mode 1 it shows amber: `run_led_r`=1, with `run_led_g`=1 as well when AMBER_MIX=1. In mode 2 it is dark. In mode 3 only the green die is used, for blinking.
- R10: The mode code is 0 Run, 1 Stop with I/O scan, 2 Stop without I/O scan, 3 Stopped/Faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_run | input | 1 | Debounced switch level, 1 = Run position |
| sw_ctl_en | input | 1 | Enables mode control by the switch |
| stop_io_scan | input | 1 | Selects whether the stopped mode keeps scanning I/O |
| fatal_flt | input | 1 | Fatal fault present |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| mode | output | 2 | Operating mode code (R10) |
| run_led_g | output | 1 | Run indicator green die |
| run_led_r | output | 1 | Run indicator red die (amber) |
| fault_led | output | 1 | Fault indicator |
| clr_req | output | 1 | One-cycle request to clear the fault tables |

## Verification
On every cycle the assertions check the local rules. These are fault entry, holding the mode with switch control off, the clear request being one cycle long and coinciding with Run, leaving the faulted mode only through a clear, the Fault indicator tracking the faulted mode, and the indicator colours in Run and in Stop without I/O scan. The bench scenarios cover what depends on counted ticks: the blink pattern against the tick count, expiry of the window at its exact tick, restarts after short dwells that must not extend the window, and reopening a window after it has expired.

// File: rtl/runstop_pkg.sv
package runstop_pkg;
   typedef enum logic [1:0] {
      MODE_RUN       = 2'd0,
      MODE_STOP_SCAN = 2'd1,
      MODE_STOP_IDLE = 2'd2,
      MODE_FAULTED   = 2'd3
   } mode_e;

   typedef enum logic [1:0] {
      CORE_RUN   = 2'd0,
      CORE_STOP  = 2'd1,
      CORE_FAULT = 2'd2
   } core_e;

   typedef enum logic [1:0] {
      SEQ_IDLE       = 2'd0,
      SEQ_RUN_DWELL  = 2'd1,
      SEQ_WAIT_RUN   = 2'd2,
      SEQ_STOP_DWELL = 2'd3
   } seq_e;
endpackage

// File: rtl/runstop_cnt.sv
module runstop_cnt #(
   parameter int LIMIT    = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic reached
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] TOP_V  = W'(LIMIT);
   localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("runstop_cnt: LIMIT must be at least 1");
   end

   logic [W-1:0] cnt;

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk) begin
         if (!rst_n)                   cnt <= '0;
         else if (clr)                 cnt <= '0;
         else if (inc && cnt != TOP_V) cnt <= cnt + 1'b1;
      end
      assign reached = (cnt == TOP_V);
   end else begin : g_wrap
      always_ff @(posedge clk) begin
         if (!rst_n)   cnt <= '0;
         else if (clr) cnt <= '0;
         else if (inc) cnt <= (cnt == LAST_V) ? '0 : cnt + 1'b1;
      end
      assign reached = (cnt == LAST_V);
   end
endmodule

// File: rtl/runstop_swedge.sv
module runstop_swedge (
   input  logic clk,
   input  logic rst_n,
   input  logic sw_run,
   input  logic en,
   output logic rise,
   output logic fall
);
   logic sw_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sw_q <= 1'b0;
      else        sw_q <= sw_run;
   end

   assign rise = en &  sw_run & ~sw_q;
   assign fall = en & ~sw_run &  sw_q;
endmodule

// File: rtl/runstop_clrseq.sv
module runstop_clrseq
   import runstop_pkg::*;
#(
   parameter int MIN_DWELL = 500,
   parameter int WINDOW    = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_fault,
   input  logic rise,
   input  logic fall,
   input  logic tick,
   output logic win_open,
   output logic clr_hit
);
   seq_e ph, ph_nxt;
   logic dwell_ok, win_last, dwell_clr, expire;

   runstop_cnt #(.LIMIT(MIN_DWELL), .SATURATE(1'b1)) u_dwell (
      .clk(clk), .rst_n(rst_n), .clr(dwell_clr), .inc(tick), .reached(dwell_ok)
   );

   runstop_cnt #(.LIMIT(WINDOW), .SATURATE(1'b0)) u_window (
      .clk(clk), .rst_n(rst_n), .clr(ph == SEQ_IDLE), .inc(tick), .reached(win_last)
   );

   assign clr_hit = (ph == SEQ_STOP_DWELL) && rise && dwell_ok;
   assign expire  = (ph != SEQ_IDLE) && tick && win_last;

   always_comb begin
      ph_nxt = ph;
      if (!in_fault) begin
         ph_nxt = SEQ_IDLE;
      end else if (clr_hit || expire) begin
         ph_nxt = SEQ_IDLE;
      end else begin
         unique case (ph)
            SEQ_IDLE:       if (rise) ph_nxt = SEQ_RUN_DWELL;
            SEQ_RUN_DWELL:  if (fall) ph_nxt = dwell_ok ? SEQ_STOP_DWELL : SEQ_WAIT_RUN;
            SEQ_WAIT_RUN:   if (rise) ph_nxt = SEQ_RUN_DWELL;
            SEQ_STOP_DWELL: if (rise) ph_nxt = SEQ_RUN_DWELL;
            default:        ph_nxt = SEQ_IDLE;
         endcase
      end
   end

   assign dwell_clr = (ph_nxt != ph) || (ph == SEQ_IDLE);
   assign win_open  = (ph != SEQ_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) ph <= SEQ_IDLE;
      else        ph <= ph_nxt;
   end
endmodule

// File: rtl/runstop_led.sv
module runstop_led
   import runstop_pkg::*;
#(
   parameter int BLINK_HALF = 250,
   parameter bit AMBER_MIX  = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  mode_e mode,
   input  logic  win_open,
   input  logic  tick,
   output logic  led_g,
   output logic  led_r,
   output logic  led_fault
);
   logic half_done, blink_on, amber_g;

   runstop_cnt #(.LIMIT(BLINK_HALF), .SATURATE(1'b0)) u_blink (
      .clk(clk), .rst_n(rst_n), .clr(!win_open), .inc(tick), .reached(half_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 blink_on <= 1'b1;
      else if (!win_open)         blink_on <= 1'b1;
      else if (tick && half_done) blink_on <= ~blink_on;
   end

   if (AMBER_MIX) begin : g_amber_mix
      assign amber_g = 1'b1;
   end else begin : g_amber_die
      assign amber_g = 1'b0;
   end

   always_comb begin
      led_g     = 1'b0;
      led_r     = 1'b0;
      led_fault = 1'b0;
      unique case (mode)
         MODE_RUN:       led_g = 1'b1;
         MODE_STOP_SCAN: begin led_g = amber_g; led_r = 1'b1; end
         MODE_STOP_IDLE: ;
         MODE_FAULTED:   begin led_g = win_open & blink_on; led_fault = 1'b1; end
         default:        led_fault = 1'b1;
      endcase
   end
endmodule

// File: rtl/runstop_ctrl.sv
module runstop_ctrl
   import runstop_pkg::*;
#(
   parameter int MIN_DWELL_MS  = 500,
   parameter int WINDOW_MS     = 5000,
   parameter int BLINK_HALF_MS = 250,
   parameter bit AMBER_MIX     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sw_run,
   input  logic       sw_ctl_en,
   input  logic       stop_io_scan,
   input  logic       fatal_flt,
   input  logic       ms_tick,
   output logic [1:0] mode,
   output logic       run_led_g,
   output logic       run_led_r,
   output logic       fault_led,
   output logic       clr_req
);
   if (MIN_DWELL_MS < 1) begin : g_bad_dwell
      $error("runstop_ctrl: MIN_DWELL_MS must be at least 1");
   end
   if (WINDOW_MS <= 2 * MIN_DWELL_MS) begin : g_bad_window
      $error("runstop_ctrl: WINDOW_MS must exceed two dwell times");
   end
   if (BLINK_HALF_MS < 1) begin : g_bad_blink
      $error("runstop_ctrl: BLINK_HALF_MS must be at least 1");
   end

   core_e core, core_nxt;
   mode_e mode_w;
   logic  rise, fall, win_open, clr_hit;

   runstop_swedge u_edge (
      .clk(clk), .rst_n(rst_n), .sw_run(sw_run), .en(sw_ctl_en),
      .rise(rise), .fall(fall)
   );

   runstop_clrseq #(.MIN_DWELL(MIN_DWELL_MS), .WINDOW(WINDOW_MS)) u_seq (
      .clk(clk), .rst_n(rst_n), .in_fault(core == CORE_FAULT),
      .rise(rise), .fall(fall), .tick(ms_tick),
      .win_open(win_open), .clr_hit(clr_hit)
   );

   always_comb begin
      core_nxt = core;
      if (core != CORE_FAULT && fatal_flt) begin
         core_nxt = CORE_FAULT;
      end else begin
         unique case (core)
            CORE_RUN:   if (sw_ctl_en && !sw_run) core_nxt = CORE_STOP;
            CORE_STOP:  if (sw_ctl_en &&  sw_run) core_nxt = CORE_RUN;
            CORE_FAULT: if (clr_hit)              core_nxt = CORE_RUN;
            default:    core_nxt = CORE_STOP;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         core    <= CORE_STOP;
         clr_req <= 1'b0;
      end else begin
         core    <= core_nxt;
         clr_req <= (core == CORE_FAULT) && clr_hit;
      end
   end

   always_comb begin
      unique case (core)
         CORE_RUN:   mode_w = MODE_RUN;
         CORE_STOP:  mode_w = stop_io_scan ? MODE_STOP_SCAN : MODE_STOP_IDLE;
         default:    mode_w = MODE_FAULTED;
      endcase
   end

   assign mode = mode_w;

   runstop_led #(.BLINK_HALF(BLINK_HALF_MS), .AMBER_MIX(AMBER_MIX)) u_led (
      .clk(clk), .rst_n(rst_n), .mode(mode_w), .win_open(win_open), .tick(ms_tick),
      .led_g(run_led_g), .led_r(run_led_r), .led_fault(fault_led)
   );
endmodule

// File: rtl/runstop_chk.sv
module runstop_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sw_ctl_en,
   input logic       fatal_flt,
   input logic [1:0] mode,
   input logic       run_led_g,
   input logic       run_led_r,
   input logic       fault_led,
   input logic       clr_req
);
   AST_HOLD_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_ctl_en && !fatal_flt && mode == 2'd0) |=> (mode == 2'd0)); // R3

   AST_FATAL_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal_flt && mode != 2'd3) |=> (mode == 2'd3)); // R4

   AST_FAULT_LED_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      fault_led == (mode == 2'd3)); // R4

   AST_CLEAR_WITH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |-> (mode == 2'd0)); // R6

   AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> !clr_req); // R6

   AST_FAULT_EXIT_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd3) |=> (mode == 2'd3 || clr_req)); // R8

   AST_RUN_GREEN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0) |-> (run_led_g && !run_led_r)); // R9

   AST_IDLE_STOP_DARK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd2) |-> (!run_led_g && !run_led_r)); // R9
endmodule

bind runstop_ctrl runstop_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sw_ctl_en(sw_ctl_en), .fatal_flt(fatal_flt),
   .mode(mode), .run_led_g(run_led_g), .run_led_r(run_led_r),
   .fault_led(fault_led), .clr_req(clr_req)
);

// File: tb/sim_runstop_ctrl.sv
module sim_runstop_ctrl;
   localparam int MIN = 4;
   localparam int WIN = 30;
   localparam int BH  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sw = 1'b0, en = 1'b1, scan = 1'b1, fatal = 1'b0, tick = 1'b0;
   logic [1:0] mode;
   logic       led_g, led_r, fled, clr;

   int tests = 0, fails = 0, clr_seen = 0, clr_double = 0;
   logic clr_prev = 1'b0;

   always #2 clk = ~clk;

   runstop_ctrl #(.MIN_DWELL_MS(MIN), .WINDOW_MS(WIN), .BLINK_HALF_MS(BH), .AMBER_MIX(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .sw_run(sw), .sw_ctl_en(en), .stop_io_scan(scan),
      .fatal_flt(fatal), .ms_tick(tick), .mode(mode), .run_led_g(led_g),
      .run_led_r(led_r), .fault_led(fled), .clr_req(clr)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (clr) clr_seen++;
         if (clr && clr_prev) clr_double++;
         clr_prev <= clr;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", tests - fails, tests);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
   end

   initial begin
      int em;
      int eg;
      repeat (3) @(negedge clk);
      chk("R1 mode in reset", mode, 1);
      rst_n = 1'b1;
      step();
      chk("R1 mode after reset", mode, 1);
      chk("R1 fault led", fled, 0);
      chk("R1 clear request", clr, 0);

      // R2 R9 R10 sweep from Stop
      for (int s = 0; s < 2; s++)
         for (int e = 0; e < 2; e++)
            for (int w = 0; w < 2; w++) begin
               en = 1'b1; sw = 1'b0; step();
               scan = s[0]; en = e[0]; sw = w[0]; step();
               em = (e == 1 && w == 1) ? 0 : (s == 1 ? 1 : 2);
               chk("R2 R10 mode", mode, em);
               chk("R9 green", led_g, (em == 0 || em == 1) ? 1 : 0);
               chk("R9 red", led_r, (em == 1) ? 1 : 0);
               chk("R2 no clear", clr, 0);
            end

      // R3 disabled switch from Run and from Stop
      scan = 1'b1;
      for (int w = 0; w < 2; w++) begin
         en = 1'b1; sw = 1'b1; step();
         en = 1'b0; sw = w[0]; step(); step();
         chk("R3 held Run", mode, 0);
         en = 1'b1; sw = 1'b0; step();
         en = 1'b0; sw = 1'b1; step(); step();
         chk("R3 held Stop", mode, 1);
      end

      // R4 fatal entry with switch already in Run
      en = 1'b1; sw = 1'b1; step();
      fatal = 1'b1; step();
      chk("R4 faulted mode", mode, 3);
      chk("R4 fault led", fled, 1);
      chk("R4 red off", led_r, 0);
      ticks(2);
      chk("R4 no window", led_g, 0);

      // R5 open window and blink, then R6 clear
      sw = 1'b0; step(); sw = 1'b1; step();
      chk("R5 window opens green", led_g, 1);
      ticks(BH - 1);
      chk("R5 blink still on", led_g, 1);
      ticks(1);
      chk("R5 blink off", led_g, 0);
      ticks(BH);
      chk("R5 blink on again", led_g, 1);
      sw = 1'b0; step();
      ticks(MIN);
      fatal = 1'b0; sw = 1'b1; step();
      chk("R6 enters Run", mode, 0);
      chk("R6 clear pulse", clr, 1);
      step();
      chk("R6 pulse ended", clr, 0);
      chk("R6 steady green", led_g, 1);
      chk("R6 stays Run", mode, 0);

      // R8 expiry sweep over the whole window
      fatal = 1'b1; step();
      sw = 1'b0; step(); sw = 1'b1; step();
      chk("R5 open at t0", led_g, 1);
      for (int t = 1; t <= WIN + 2; t++) begin
         ticks(1);
         eg = (t < WIN && ((t / BH) % 2) == 0) ? 1 : 0;
         chk("R8 R5 green versus ticks", led_g, eg);
      end
      chk("R8 still faulted", mode, 3);
      chk("R8 no clear", clr_seen, 1);
      sw = 1'b0; step(); sw = 1'b1; step();
      chk("R8 reopened", led_g, 1);

      // R7 short dwells restart the sequence
      ticks(MIN - 1);
      sw = 1'b0; step();
      ticks(MIN);
      sw = 1'b1; step();
      chk("R7 short Run no clear", mode, 3);
      ticks(MIN);
      sw = 1'b0; step();
      ticks(MIN - 1);
      sw = 1'b1; step();
      chk("R7 short Stop no clear", mode, 3);
      ticks(MIN);
      sw = 1'b0; step();
      ticks(MIN);
      fatal = 1'b0; sw = 1'b1; step();
      chk("R7 clear after restart", mode, 0);
      chk("R7 clear pulse", clr, 1);

      // R7 R8 restart does not extend the window
      fatal = 1'b1; step();
      sw = 1'b0; step(); sw = 1'b1; step();
      ticks(3);
      sw = 1'b0; step();
      ticks(MIN);
      sw = 1'b1; step();
      ticks(MIN);
      sw = 1'b0; step();
      ticks(WIN - 3 - 2 * MIN);
      chk("R7 window expired on time", led_g, 0);
      sw = 1'b1; step();
      chk("R8 no late clear", mode, 3);
      chk("R8 late return opens new window", led_g, 1);
      ticks(WIN);
      chk("R8 second window closed", led_g, 0);

      // R5 switch control off: no window
      en = 1'b0; sw = 1'b0; step(); sw = 1'b1; step();
      chk("R5 disabled no window", led_g, 0);
      ticks(2);
      chk("R5 disabled still dark", led_g, 0);
      chk("R5 disabled faulted", mode, 3);

      step();
      chk("R6 total clear pulses", clr_seen, 2);
      chk("R6 single cycle pulses", clr_double, 0);
      summary();
      $finish;
   end
endmodule